// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps the renaming state for a 32-entry floating-point register file in a dynamically scheduled core. Each register holds a data value and a producer tag. The tag names the reservation station whose result the register is waiting for. A tag of zero means no instruction in flight targets that register, so the stored value is current.

When an instruction issues, the block answers two source lookups in the same cycle. Each lookup returns either the register value with a zero tag, or the pending producer tag. On the next clock edge the block records the issuing station's tag against the destination register. A later writer therefore replaces any earlier pending one.

Each result-bus broadcast carries a tag and a value. The value is written into every register whose tag still equals the broadcast tag, and those tags are cleared. A result from an older writer whose register has since been renamed is dropped, and this removes write-after-write hazards. The reservation stations and functional units sit outside this block.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reads back with tag 0 and value 0.
- R2: An issue with iss_vld=1 and a nonzero iss_tag sets the tag of register iss_dst to iss_tag from the next cycle on. A source lookup in the issue cycle still sees the state from before the issue.
- R3: A second issue to a register that is already pending replaces the pending tag with the newer one.
- R4: A broadcast with cdb_vld=1 and a nonzero cdb_tag writes cdb_data into every register whose tag equals cdb_tag and sets their tags to 0 from the next cycle on.
- R5: A broadcast whose tag does not match a register's current tag leaves that register's tag and value unchanged. A stale writer's result never lands in a renamed register.
- R6: When an issue to register r and a broadcast matching r's old tag fall in the same cycle, r ends with the new issue tag.
- R7: A lookup of a register whose tag equals the tag of a valid broadcast in the same cycle returns cdb_data with tag 0.
- R8: A lookup of a pending register with no matching broadcast returns its tag. A lookup of a register with tag 0 returns its stored value with tag 0.
- R9: An issue with iss_tag=0 and a broadcast with cdb_tag=0 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| iss_dst | input | 5 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing reservation station (nonzero) |
| cdb_vld | input | 1 | Result broadcast valid |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_data | input | 64 | Broadcast result value |
| src_a_val | output | 64 | First source value (meaningful when src_a_tag is 0) |
| src_a_tag | output | 4 | First source pending tag, 0 when ready |
| src_b_val | output | 64 | Second source value (meaningful when src_b_tag is 0) |
| src_b_tag | output | 4 | Second source pending tag, 0 when ready |

## Verification
Two pairs of functions can fall in one cycle. An issue can rename a register while a broadcast clears it. A lookup can read a register while its producer broadcasts. The bench provokes the first by driving an issue to a pending register together with a broadcast of that register's old tag, and judges it by reading the surviving tag on the following cycle. It provokes the second by pointing a source lookup at a register while its tag is on the bus, and judges it by requiring the bus value with a zero tag in that same cycle. Overlapping writers to one register are then retired out of order, and only the last writer's value may remain.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int unsigned DEF_NREG = 32;
  localparam int unsigned DEF_TAGW = 4;
  localparam int unsigned DEF_DW   = 64;
endpackage

// File: rtl/rst_slot.sv
module rst_slot #(
  parameter int unsigned TAGW = 4,
  parameter int unsigned DW   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ren_en,
  input  logic [TAGW-1:0] ren_tag,
  input  logic            cdb_vld,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_data,
  output logic [TAGW-1:0] tag_q,
  output logic [DW-1:0]   val_q
);
  logic            hit;
  logic            tag_en, val_en;
  logic [TAGW-1:0] tag_d;

  always_comb begin
    hit    = cdb_vld && (tag_q != '0) && (tag_q == cdb_tag);
    val_en = hit;
    tag_en = hit || ren_en;
    // rename beats clear in the same cycle
    tag_d  = ren_en ? ren_tag : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= cdb_data;
    end
  end
endmodule

// File: rtl/rst_port.sv
module rst_port #(
  parameter int unsigned NREG = 32,
  parameter int unsigned TAGW = 4,
  parameter int unsigned DW   = 64,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0][TAGW-1:0] tags,
  input  logic [NREG-1:0][DW-1:0]   vals,
  input  logic [IDXW-1:0]           idx,
  input  logic                      cdb_vld,
  input  logic [TAGW-1:0]           cdb_tag,
  input  logic [DW-1:0]             cdb_data,
  output logic [DW-1:0]             val,
  output logic [TAGW-1:0]           tag
);
  logic [TAGW-1:0] rd_tag;
  logic [DW-1:0]   rd_val;
  logic            byp;

  always_comb begin
    rd_tag = tags[idx];
    rd_val = vals[idx];
    byp    = cdb_vld && (rd_tag != '0) && (rd_tag == cdb_tag);
    tag    = byp ? '0 : rd_tag;
    val    = byp ? cdb_data : rd_val;
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG,
  parameter int unsigned TAGW = DEF_TAGW,
  parameter int unsigned DW   = DEF_DW,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_vld,
  input  logic [IDXW-1:0] iss_src_a,
  input  logic [IDXW-1:0] iss_src_b,
  input  logic [IDXW-1:0] iss_dst,
  input  logic [TAGW-1:0] iss_tag,
  input  logic            cdb_vld,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_data,
  output logic [DW-1:0]   src_a_val,
  output logic [TAGW-1:0] src_a_tag,
  output logic [DW-1:0]   src_b_val,
  output logic [TAGW-1:0] src_b_tag
);
  logic [NREG-1:0][TAGW-1:0] tag_q;
  logic [NREG-1:0][DW-1:0]   val_q;
  logic [NREG-1:0]           ren_en;
  logic                      iss_ok;

  always_comb begin
    iss_ok = iss_vld && (iss_tag != '0);
    for (int i = 0; i < NREG; i++) begin
      ren_en[i] = iss_ok && (iss_dst == IDXW'(i));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    rst_slot #(.TAGW(TAGW), .DW(DW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ren_en  (ren_en[g]),
      .ren_tag (iss_tag),
      .cdb_vld (cdb_vld),
      .cdb_tag (cdb_tag),
      .cdb_data(cdb_data),
      .tag_q   (tag_q[g]),
      .val_q   (val_q[g])
    );
  end

  rst_port #(.NREG(NREG), .TAGW(TAGW), .DW(DW)) u_port_a (
    .tags(tag_q), .vals(val_q), .idx(iss_src_a),
    .cdb_vld(cdb_vld), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .val(src_a_val), .tag(src_a_tag)
  );

  rst_port #(.NREG(NREG), .TAGW(TAGW), .DW(DW)) u_port_b (
    .tags(tag_q), .vals(val_q), .idx(iss_src_b),
    .cdb_vld(cdb_vld), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .val(src_b_val), .tag(src_b_tag)
  );
endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned TAGW = 4,
  parameter int unsigned DW   = 64,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_vld,
  input logic [IDXW-1:0]           iss_src_a,
  input logic [IDXW-1:0]           iss_dst,
  input logic [TAGW-1:0]           iss_tag,
  input logic                      cdb_vld,
  input logic [TAGW-1:0]           cdb_tag,
  input logic [DW-1:0]             cdb_data,
  input logic [DW-1:0]             src_a_val,
  input logic [TAGW-1:0]           src_a_tag,
  input logic [NREG-1:0][TAGW-1:0] tag_q,
  input logic [NREG-1:0][DW-1:0]   val_q
);
  // R2 R3 R6
  rename_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && iss_tag != '0) |=> (tag_q[$past(iss_dst)] == $past(iss_tag)));

  // R7
  bypass_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_vld && cdb_tag != '0 && tag_q[iss_src_a] == cdb_tag)
      |-> (src_a_tag == '0 && src_a_val == cdb_data));

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R4
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_vld && cdb_tag != '0 && tag_q[g] == cdb_tag &&
       !(iss_vld && iss_tag != '0 && iss_dst == IDXW'(g)))
        |=> (tag_q[g] == '0 && val_q[g] == $past(cdb_data)));

    // R5 R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cdb_vld && cdb_tag != '0 && tag_q[g] == cdb_tag) &&
       !(iss_vld && iss_tag != '0 && iss_dst == IDXW'(g)))
        |=> ($stable(tag_q[g]) && $stable(val_q[g])));
  end
endmodule

bind rename_status_table rename_status_table_chk #(.NREG(NREG), .TAGW(TAGW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_src_a(iss_src_a),
  .iss_dst(iss_dst), .iss_tag(iss_tag), .cdb_vld(cdb_vld), .cdb_tag(cdb_tag),
  .cdb_data(cdb_data), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
  .tag_q(tag_q), .val_q(val_q)
);

// File: tb/sim_rename_status_table.sv
`timescale 1ns/1ps
module sim_rename_status_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_vld;
  logic [4:0]  iss_src_a, iss_src_b, iss_dst;
  logic [3:0]  iss_tag;
  logic        cdb_vld;
  logic [3:0]  cdb_tag;
  logic [63:0] cdb_data;
  logic [63:0] src_a_val, src_b_val;
  logic [3:0]  src_a_tag, src_b_tag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rename_status_table u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .cdb_vld(cdb_vld), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .src_a_val(src_a_val), .src_a_tag(src_a_tag),
    .src_b_val(src_b_val), .src_b_tag(src_b_tag)
  );

  function automatic logic [3:0] tag_of(int r);
    return 4'((r % 15) + 1);
  endfunction

  function automatic logic [63:0] data_of(int t);
    return 64'hC0DE_0000_0000_0000 + 64'(t * 977);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after a falling edge, settle, inputs stable across the next rise
  task automatic drive(logic iv, int dst, logic [3:0] it,
                       logic cv, logic [3:0] ct, logic [63:0] cd);
    @(negedge clk);
    iss_vld = iv; iss_dst = 5'(dst); iss_tag = it;
    cdb_vld = cv; cdb_tag = ct; cdb_data = cd;
    #0.5;
  endtask

  task automatic idle();
    drive(1'b0, 0, 4'd0, 1'b0, 4'd0, 64'd0);
  endtask

  task automatic look(int a, int b);
    iss_src_a = 5'(a); iss_src_b = 5'(b);
    #0.5;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_vld = 0; iss_src_a = 0; iss_src_b = 0; iss_dst = 0; iss_tag = 0;
    cdb_vld = 0; cdb_tag = 0; cdb_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state of every register
    idle();
    for (int r = 0; r < 32; r++) begin
      look(r, 31 - r);
      chk("R1 tag", 64'(src_a_tag), 64'd0);
      chk("R1 val", src_a_val, 64'd0);
      chk("R1 tagb", 64'(src_b_tag), 64'd0);
    end

    // R2 rename every register; same-cycle lookup sees old state
    for (int r = 0; r < 32; r++) begin
      drive(1'b1, r, tag_of(r), 1'b0, 4'd0, 64'd0);
      look(r, r);
      chk("R2 same-cycle old tag", 64'(src_a_tag), 64'd0);
    end
    idle();
    for (int r = 0; r < 32; r++) begin
      look(r, 31 - r);
      chk("R2 R8 pending tag a", 64'(src_a_tag), 64'(tag_of(r)));
      chk("R2 R8 pending tag b", 64'(src_b_tag), 64'(tag_of(31 - r)));
    end

    // R7 bypass, R4 retire for every tag
    for (int t = 1; t <= 15; t++) begin
      drive(1'b0, 0, 4'd0, 1'b1, 4'(t), data_of(t));
      look(t - 1, t + 14);
      chk("R7 bypass tag", 64'(src_a_tag), 64'd0);
      chk("R7 bypass val", src_a_val, data_of(t));
      chk("R7 bypass val b", src_b_val, data_of(t));
    end
    idle();
    for (int r = 0; r < 32; r++) begin
      look(r, r);
      chk("R4 cleared tag", 64'(src_a_tag), 64'd0);
      chk("R4 R8 written val", src_a_val, data_of(int'(tag_of(r))));
    end

    // R3 R5 overlapping writers to register 5
    drive(1'b1, 5, 4'd3, 1'b0, 4'd0, 64'd0);
    drive(1'b1, 5, 4'd7, 1'b0, 4'd0, 64'd0);
    idle(); look(5, 6);
    chk("R3 newest tag", 64'(src_a_tag), 64'd7);
    chk("R5 neighbour untouched", src_b_val, data_of(int'(tag_of(6))));
    drive(1'b0, 0, 4'd0, 1'b1, 4'd3, 64'h5157_A1E0);
    look(5, 5);
    chk("R5 stale no bypass", 64'(src_a_tag), 64'd7);
    idle(); look(5, 5);
    chk("R5 stale tag kept", 64'(src_a_tag), 64'd7);
    drive(1'b0, 0, 4'd0, 1'b1, 4'd7, 64'h1A57_0077);
    idle(); look(5, 5);
    chk("R3 last writer tag", 64'(src_a_tag), 64'd0);
    chk("R3 last writer val", src_a_val, 64'h1A57_0077);

    // R6 rename and retire of register 9 in one cycle
    drive(1'b1, 9, 4'd4, 1'b0, 4'd0, 64'd0);
    drive(1'b1, 9, 4'd6, 1'b1, 4'd4, 64'h0000_0444);
    idle(); look(9, 9);
    chk("R6 issue wins", 64'(src_a_tag), 64'd6);
    drive(1'b0, 0, 4'd0, 1'b1, 4'd6, 64'h0000_0666);
    idle(); look(9, 9);
    chk("R6 final val", src_a_val, 64'h0000_0666);
    chk("R6 final tag", 64'(src_a_tag), 64'd0);

    // R9 zero tags have no effect
    drive(1'b1, 2, 4'd0, 1'b0, 4'd0, 64'd0);
    idle(); look(2, 2);
    chk("R9 zero issue tag", 64'(src_a_tag), 64'd0);
    chk("R9 zero issue val", src_a_val, data_of(int'(tag_of(2))));
    drive(1'b0, 0, 4'd0, 1'b1, 4'd0, 64'hDEAD_BEEF);
    look(2, 3);
    chk("R9 zero bus no bypass", src_a_val, data_of(int'(tag_of(2))));
    idle(); look(2, 3);
    chk("R9 zero bus val", src_a_val, data_of(int'(tag_of(2))));
    chk("R9 zero bus val b", src_b_val, data_of(int'(tag_of(3))));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule